// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Dual Periodic Interrupts

This block is a real-time clock peripheral for a small processor I/O bus. A prescaler divides the system clock into a one-cycle strobe once per millisecond. Each strobe advances a 16-bit count. Two interrupt sources watch that count. The short source fires every 32 ms. The long source fires once per minute, at a count of 60000, and at that point the count returns to zero. Each source carries its own 4-bit priority level, which software sets through a pair of write strobes. The interrupt arbiter that consumes these requests lies outside this block.

The processor reads the current count with a select strobe, and the value is returned in the same cycle. When the device is switched off, a read hands the caller's data back unchanged and flags an illegal-instruction condition. While the device is off, the count holds its value and no request is raised. Enabling the device again restarts the prescaler from zero.

Top module: `ms_rtc`

## Requirements
- R1: While `dev_en` is 1, the count rises by exactly one on each millisecond strobe. Strobes are `TICK_DIV` clock cycles apart, and the count does not change between strobes.
- R2: When the count takes a new value whose low `FAST_LOG2` bits (5 by default, i.e. a multiple of 32) are all zero, `fast_req_valid` is 1 for exactly one cycle. That cycle is the first cycle in which the new value is visible.
- R3: When the count would reach `WRAP_COUNT` (60000 by default), it becomes 0 instead. `min_req_valid` is 1 for that one cycle. The count never reads `WRAP_COUNT` or more.
- R4: At the wrap, `fast_req_valid` and `min_req_valid` are both 1 in the same cycle, each on its own port.
- R5: `lvl_wr_fast` or `lvl_wr_min` loads `lvl_wdata` (4 bits) into that source's level register. Each request presents its own level on `*_req_level` while its valid is 1. Both levels reset to 0.
- R6: With `io_sel`=1 and `dev_en`=1, `io_rdata` shows the count in the same cycle and `io_illegal` is 0. A read in the cycle of a strobe returns the value before the increment. With `io_sel`=0, `io_rdata` is 0.
- R7: With `dev_en`=0, `io_sel`=1 gives `io_rdata`=`io_wdata` and `io_illegal`=1. No strobe, no count change and no request occurs. Setting `dev_en` to 1 again resumes counting from the held value.
- R8: Synchronous active-high `rst` clears the count, the prescaler and both level registers. After reset, counting restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_en | input | 1 | Device enable; 0 makes I/O illegal and freezes the clock |
| lvl_wr_fast | input | 1 | Load the 32 ms source level |
| lvl_wr_min | input | 1 | Load the one-minute source level |
| lvl_wdata | input | 4 | Level value to load |
| io_sel | input | 1 | I/O read select strobe |
| io_wdata | input | 16 | Data from the processor, returned when disabled |
| io_rdata | output | 16 | Read data |
| io_illegal | output | 1 | Illegal-instruction flag for a disabled access |
| fast_req_valid | output | 1 | 32 ms interrupt request pulse |
| fast_req_level | output | 4 | Priority level of the 32 ms request |
| min_req_valid | output | 1 | One-minute interrupt request pulse |
| min_req_level | output | 4 | Priority level of the one-minute request |

## Verification
The bench builds the block with `TICK_DIV`=4 and `WRAP_COUNT`=320, keeping `FAST_LOG2`=5 and the 16-bit count. These values bring the full wrap, with both requests on the same cycle, within about 1300 cycles. Because 320 is a multiple of 32, the wrap coincidence of the full-size block is preserved. The short divider also lets the bench measure the exact strobe spacing, and it keeps the disable/re-enable and mid-count reset cases cheap.

// File: rtl/ms_rtc_pkg.sv
package ms_rtc_pkg;
  localparam int LVL_W   = 4;
  localparam int NUM_SRC = 2;
  localparam int SRC_FAST = 0;
  localparam int SRC_MIN  = 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/ms_rtc_prescaler.sv
module ms_rtc_prescaler #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
      tick <= 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick); // R7
endmodule

// File: rtl/ms_rtc_counter.sv
module ms_rtc_counter #(
  parameter int CNT_W      = 16,
  parameter int WRAP_COUNT = 60000,
  parameter int FAST_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_fast,
  output logic             hit_wrap
);
  localparam logic [CNT_W-1:0] WRAP_V = CNT_W'(WRAP_COUNT);

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt      = cnt + 1'b1;
    hit_wrap = step && (nxt == WRAP_V);
    hit_fast = step && (nxt[FAST_LOG2-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (hit_wrap) cnt <= '0;
    else if (step)     cnt <= nxt;
  end

  AST_CNT_BELOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    cnt < WRAP_V); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R1
endmodule

// File: rtl/ms_rtc_irq.sv
module ms_rtc_irq
  import ms_rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_wr,
  input  lvl_t lvl_wdata,
  input  logic hit,
  output logic req_valid,
  output lvl_t req_level
);
  lvl_t lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= '0;
      req_valid <= 1'b0;
      req_level <= '0;
    end else begin
      if (lvl_wr) lvl_q <= lvl_wdata;
      req_valid <= hit;
      req_level <= hit ? lvl_q : '0;
    end
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R2
endmodule

// File: rtl/ms_rtc.sv
module ms_rtc
  import ms_rtc_pkg::*;
#(
  parameter int TICK_DIV   = 125000,
  parameter int CNT_W      = 16,
  parameter int WRAP_COUNT = 60000,
  parameter int FAST_LOG2  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_en,
  input  logic             lvl_wr_fast,
  input  logic             lvl_wr_min,
  input  logic [3:0]       lvl_wdata,
  input  logic             io_sel,
  input  logic [CNT_W-1:0] io_wdata,
  output logic [CNT_W-1:0] io_rdata,
  output logic             io_illegal,
  output logic             fast_req_valid,
  output logic [3:0]       fast_req_level,
  output logic             min_req_valid,
  output logic [3:0]       min_req_level
);
  logic             tick;
  logic             step;
  logic [CNT_W-1:0] cnt;
  logic             hit_fast, hit_wrap;
  logic [NUM_SRC-1:0] src_hit, src_wr, src_vld;
  lvl_t               src_lvl [NUM_SRC];

  ms_rtc_prescaler #(.TICK_DIV(TICK_DIV)) presc_i (
    .clk(clk), .rst(rst), .en(dev_en), .tick(tick)
  );

  assign step = tick && dev_en;

  ms_rtc_counter #(
    .CNT_W(CNT_W), .WRAP_COUNT(WRAP_COUNT), .FAST_LOG2(FAST_LOG2)
  ) cnt_i (
    .clk(clk), .rst(rst), .step(step), .cnt(cnt),
    .hit_fast(hit_fast), .hit_wrap(hit_wrap)
  );

  assign src_hit[SRC_FAST] = hit_fast;
  assign src_hit[SRC_MIN]  = hit_wrap;
  assign src_wr[SRC_FAST]  = lvl_wr_fast;
  assign src_wr[SRC_MIN]   = lvl_wr_min;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ms_rtc_irq irq_i (
      .clk(clk), .rst(rst), .lvl_wr(src_wr[g]), .lvl_wdata(lvl_wdata),
      .hit(src_hit[g]), .req_valid(src_vld[g]), .req_level(src_lvl[g])
    );
  end

  assign fast_req_valid = src_vld[SRC_FAST];
  assign fast_req_level = src_lvl[SRC_FAST];
  assign min_req_valid  = src_vld[SRC_MIN];
  assign min_req_level  = src_lvl[SRC_MIN];

  always_comb begin
    io_illegal = io_sel && !dev_en;
    if (!io_sel)     io_rdata = '0;
    else if (dev_en) io_rdata = cnt;
    else             io_rdata = io_wdata;
  end

  AST_WRAP_BOTH: assert property (@(posedge clk) disable iff (rst)
    min_req_valid |-> fast_req_valid); // R4
  AST_FAST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    fast_req_valid |-> (cnt[FAST_LOG2-1:0] == '0)); // R2
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !dev_en |=> !(fast_req_valid || min_req_valid)); // R7
endmodule

// File: tb/ms_rtc_tb_top.sv
`timescale 1ns/1ps
module ms_rtc_tb_top;
  localparam int DIV  = 4;
  localparam int WRAP = 320;

  logic        clk = 1'b0;
  logic        rst, dev_en, lvl_wr_fast, lvl_wr_min, io_sel;
  logic [3:0]  lvl_wdata;
  logic [15:0] io_wdata, io_rdata;
  logic        io_illegal, fast_req_valid, min_req_valid;
  logic [3:0]  fast_req_level, min_req_level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ms_rtc #(.TICK_DIV(DIV), .CNT_W(16), .WRAP_COUNT(WRAP), .FAST_LOG2(5)) dut_i (
    .clk(clk), .rst(rst), .dev_en(dev_en), .lvl_wr_fast(lvl_wr_fast),
    .lvl_wr_min(lvl_wr_min), .lvl_wdata(lvl_wdata), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_illegal(io_illegal),
    .fast_req_valid(fast_req_valid), .fast_req_level(fast_req_level),
    .min_req_valid(min_req_valid), .min_req_level(min_req_level)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(io_rdata == 16'd0, "R8 count after reset", io_rdata, 0);
    check(!fast_req_valid && !min_req_valid, "R8 no request after reset",
          fast_req_valid + min_req_valid, 0);
    check(!io_illegal, "R6 no illegal flag when enabled", io_illegal, 0);
  endtask

  task automatic t_tick_rate();
    int v0, gap;
    v0 = io_rdata;
    while (io_rdata == v0) @(negedge clk);
    check(io_rdata == v0 + 1, "R1 step of one", io_rdata, v0 + 1);
    v0 = io_rdata; gap = 0;
    while (io_rdata == v0) begin @(negedge clk); gap++; end
    check(gap == DIV, "R1 strobe spacing", gap, DIV);
    check(io_rdata == v0 + 1, "R6 pre-increment read before strobe edge", io_rdata, v0 + 1);
    io_sel = 1'b0; #1;
    check(io_rdata == 16'd0, "R6 rdata zero without select", io_rdata, 0);
    io_sel = 1'b1;
  endtask

  task automatic t_levels(input logic [3:0] lf, input logic [3:0] lm);
    @(negedge clk); lvl_wdata = lf; lvl_wr_fast = 1'b1;
    @(negedge clk); lvl_wr_fast = 1'b0; lvl_wdata = lm; lvl_wr_min = 1'b1;
    @(negedge clk); lvl_wr_min = 1'b0; lvl_wdata = 4'hF;
  endtask

  task automatic t_fast(input int exp_lvl, input string tag);
    int guard = 0;
    while (!fast_req_valid && guard < 1000) begin @(negedge clk); guard++; end
    check(fast_req_valid, "R2 fast request seen", fast_req_valid, 1);
    check(io_rdata % 32 == 0, "R2 fast request on multiple of 32", io_rdata % 32, 0);
    check(fast_req_level == exp_lvl, tag, fast_req_level, exp_lvl);
    @(negedge clk);
    check(!fast_req_valid, "R2 fast request lasts one cycle", fast_req_valid, 0);
  endtask

  task automatic t_wrap();
    int prev = 0, guard = 0, nfast = 0;
    while (!min_req_valid && guard < 3000) begin
      prev = io_rdata;
      @(negedge clk); guard++;
      if (fast_req_valid && !min_req_valid) nfast++;
    end
    check(min_req_valid, "R3 minute request seen", min_req_valid, 1);
    check(prev == WRAP - 1, "R3 last value before wrap", prev, WRAP - 1);
    check(io_rdata == 16'd0, "R3 count wraps to zero", io_rdata, 0);
    check(fast_req_valid, "R4 fast request with minute request", fast_req_valid, 1);
    check(min_req_level == 4'd9, "R5 minute level", min_req_level, 9);
    check(fast_req_level == 4'd5, "R5 fast level at wrap", fast_req_level, 5);
    @(negedge clk);
    check(!min_req_valid, "R3 minute request lasts one cycle", min_req_valid, 0);
    check(nfast >= 1, "R2 fast requests before wrap", nfast, 1);
  endtask

  task automatic t_disable();
    int held, nreq = 0;
    @(negedge clk);
    held = io_rdata;
    dev_en = 1'b0; io_wdata = 16'hBEEF; #1;
    check(io_rdata == 16'hBEEF, "R7 disabled read returns data", io_rdata, 16'hBEEF);
    check(io_illegal, "R7 illegal flag", io_illegal, 1);
    repeat (200) begin
      @(negedge clk);
      if (fast_req_valid || min_req_valid) nreq++;
    end
    check(nreq == 0, "R7 no requests while disabled", nreq, 0);
    dev_en = 1'b1; #1;
    check(io_rdata == held, "R7 count held while disabled", io_rdata, held);
    check(!io_illegal, "R7 illegal flag clears", io_illegal, 0);
    repeat (DIV + 2) @(negedge clk);
    check(io_rdata == held + 1, "R7 counting resumes", io_rdata, held + 1);
  endtask

  task automatic t_reset_mid();
    repeat (37) @(negedge clk);
    do_reset();
    t_fast(0, "R8 level cleared by reset");
  endtask

  initial begin
    rst = 1'b1; dev_en = 1'b1; lvl_wr_fast = 1'b0; lvl_wr_min = 1'b0;
    lvl_wdata = 4'h0; io_sel = 1'b1; io_wdata = 16'h1234;
    do_reset();
    t_tick_rate();
    t_levels(4'd5, 4'd9);
    t_fast(5, "R5 fast level");
    t_wrap();
    t_disable();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule